// File: doc/BRIEF.md
# Phosphor-Decay Pixel Readout Filter

This stage sits between the read data port of a raster framebuffer and the color pins of a VGA output running 640x480 at 60 Hz. Every stored word carries a small frame tag beside its color, recording the frame in which the pixel was captured. The stage keeps its own frame number, which advances once per displayed frame. It subtracts each pixel's tag from that number to get the pixel's age. Depending on the selected policy, a pixel inside the allowed age is either shown unchanged or shown dimmer as it ages. A pixel past the allowed age is shown as black. This imitates the fading glow of a vector tube instead of a plain scan-out.

Sync generation and memory access happen upstream. The raster generator presents its sync and active-video signals together with the read address. The memory returns the matching word a fixed number of cycles later. The stage delays the sync and active-video signals so that they leave in step with the filtered color. The block does not depend on the raster dimensions, and 640x480 is the intended use. One tag code is reserved to mark memory that has not been written since it was cleared.

Top module: `phosphor_readout`

## Requirements
- R1: During reset and after it, until valid data comes through, every color output is 0, both sync outputs are 1 and the active output is 0. The internal frame number resets to 0.
- R2: The frame number advances by exactly one on each 1-to-0 transition of `vsync_n_in` and holds at every other cycle.
- R3: `hsync_n`, `vsync_n` and `active` repeat `hsync_n_in`, `vsync_n_in` and `active_in` delayed by RD_LAT+2 cycles. The color produced from a `pix_data` word leaves 2 cycles after that word, aligned with the sync delayed from the cycle RD_LAT earlier.
- R4: A pixel's age is (frame - tag) modulo 2^TAG_BITS-1, so a tag numerically larger than the current frame is treated as an older frame from before the wrap.
- R5: With `fade_dim` = 0, a pixel whose age is at most `age_limit` is output with its stored color unchanged. An older pixel is output as 0.
- R6: With `fade_dim` = 1, each channel of a pixel whose age is at most `age_limit` is shifted right by the age. An older pixel is output as 0.
- R7: A tag of all ones means the pixel was never written. Such a pixel is output as 0 for every limit and mode.
- R8: Whenever the delayed active flag is 0, all color outputs are 0, whatever the read data holds.
- R9: `pix_data` holds the tag in its top TAG_BITS bits. Below the tag it holds red, then green, then blue, each CH_BITS wide, with blue in the lowest bits.
- R10: The frame number counts 0 to 2^TAG_BITS-2 and then returns to 0. It never takes the reserved all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hsync_n_in | input | 1 | Horizontal sync from the raster generator, aligned with the read address |
| vsync_n_in | input | 1 | Vertical sync from the raster generator, aligned with the read address |
| active_in | input | 1 | Active-video flag aligned with the read address |
| pix_data | input | TAG_BITS+3*CH_BITS | Framebuffer word, arriving RD_LAT cycles after its address |
| age_limit | input | TAG_BITS | Largest age still displayed |
| fade_dim | input | 1 | 0 = expire abruptly, 1 = dim by age |
| red | output | CH_BITS | Filtered red channel |
| green | output | CH_BITS | Filtered green channel |
| blue | output | CH_BITS | Filtered blue channel |
| hsync_n | output | 1 | Delayed horizontal sync |
| vsync_n | output | 1 | Delayed vertical sync |
| active | output | 1 | Delayed active-video flag |

## Verification
The bench uses the default parameters: 4-bit channels, a 3-bit tag and a read latency of 2. With a 3-bit tag the frame number cycles through seven values, so a few dozen short synthetic frames carry it through several wraps. They also cover every age from 0 to 6 and the reserved tag. The 4-bit channels let a shift by any of those ages produce a distinct nonzero or zero result. The read latency of 2 makes the sync delay differ from the color delay, so a misaligned tap shows up at the outputs.

// File: rtl/phr_pkg.sv
// Package: shared raster-control type for the phosphor readout stage.
// Assumes: sync signals are active low, active-video is active high.
package phr_pkg;

    typedef struct packed {
        logic hsync_n;
        logic vsync_n;
        logic active;
    } raster_ctl_t;

    localparam raster_ctl_t CTL_IDLE = '{hsync_n: 1'b1, vsync_n: 1'b1, active: 1'b0};

endpackage

// File: rtl/phr_frame_counter.sv
// Module: phr_frame_counter
// Keeps the current frame number. It advances once on each falling edge of the
// incoming vertical sync and wraps before the reserved all-ones code.
// Assumes: vsync_n_in is synchronous to clk and idles high during reset.
module phr_frame_counter #(
    parameter int TAG_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vsync_n_in,
    output logic [TAG_BITS-1:0] frame_o
);
    localparam logic [TAG_BITS-1:0] LAST_FRAME = {{(TAG_BITS-1){1'b1}}, 1'b0};
    localparam logic [TAG_BITS-1:0] NEVER_TAG  = '1;

    logic vs_prev;
    logic vs_fall;

    assign vs_fall = vs_prev & ~vsync_n_in;

    // Remember last vsync level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vs_prev <= 1'b1;
        else        vs_prev <= vsync_n_in;
    end

    // Step the frame number on each vsync fall, skipping the reserved code.
    always_ff @(posedge clk) begin
        if (!rst_n)                        frame_o <= '0;
        else if (vs_fall && frame_o == LAST_FRAME) frame_o <= '0;
        else if (vs_fall)                  frame_o <= frame_o + 1'b1;
    end

    assert_frame_not_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_o != NEVER_TAG);

    assert_frame_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_fall |=> $stable(frame_o));

    assert_frame_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vs_fall |=> (frame_o != $past(frame_o)));

endmodule

// File: rtl/phr_ctl_delay.sv
// Module: phr_ctl_delay
// Shift register for the raster control signals. It gives the full-depth
// delayed copy and the active flag tapped after TAP stages.
// Assumes: 1 <= TAP <= DEPTH.
module phr_ctl_delay
    import phr_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAP   = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  raster_ctl_t ctl_i,
    output logic        tap_active_o,
    output raster_ctl_t ctl_o
);
    raster_ctl_t pipe [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        // Each stage copies its predecessor, idle in reset.
        always_ff @(posedge clk) begin
            if (!rst_n)      pipe[s] <= CTL_IDLE;
            else if (s == 0) pipe[s] <= ctl_i;
            else             pipe[s] <= pipe[(s == 0) ? 0 : s-1];
        end
    end

    assign tap_active_o = pipe[TAP-1].active;
    assign ctl_o        = pipe[DEPTH-1];

endmodule

// File: rtl/phr_age_filter.sv
// Module: phr_age_filter
// Two-stage filter. Stage 1 extracts the tag, computes the age modulo the frame
// period and flags expiry. Stage 2 applies the fade policy and blanking.
// Assumes: frame_i never holds the all-ones code; the tag sits above red,
// green and blue in pix_i.
module phr_age_filter #(
    parameter int CH_BITS  = 4,
    parameter int TAG_BITS = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [TAG_BITS+3*CH_BITS-1:0] pix_i,
    input  logic                          active_i,
    input  logic [TAG_BITS-1:0]           frame_i,
    input  logic [TAG_BITS-1:0]           age_limit_i,
    input  logic                          dim_i,
    output logic [3*CH_BITS-1:0]          rgb_o
);
    localparam int RGB_BITS = 3 * CH_BITS;

    logic [TAG_BITS-1:0] tag;
    logic [TAG_BITS-1:0] borrow;
    logic [TAG_BITS-1:0] age;
    logic                expired;

    logic [RGB_BITS-1:0] s1_rgb;
    logic [TAG_BITS-1:0] s1_age;
    logic                s1_expired;
    logic                s1_active;
    logic [RGB_BITS-1:0] shaped;

    assign tag    = pix_i[RGB_BITS +: TAG_BITS];
    // Going below zero skips the reserved code: subtract one extra step.
    assign borrow = {{(TAG_BITS-1){1'b0}}, (frame_i < tag)};
    assign age    = frame_i - tag - borrow;
    assign expired = (&tag) || (age > age_limit_i);

    // Stage 1: hold color, age and expiry for the policy stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_rgb     <= '0;
            s1_age     <= '0;
            s1_expired <= 1'b1;
            s1_active  <= 1'b0;
        end else begin
            s1_rgb     <= pix_i[RGB_BITS-1:0];
            s1_age     <= age;
            s1_expired <= expired;
            s1_active  <= active_i;
        end
    end

    for (genvar c = 0; c < 3; c++) begin : g_chan
        // Per channel: shift by age in dim mode, pass through otherwise.
        always_comb begin
            if (dim_i) shaped[c*CH_BITS +: CH_BITS] = s1_rgb[c*CH_BITS +: CH_BITS] >> s1_age;
            else       shaped[c*CH_BITS +: CH_BITS] = s1_rgb[c*CH_BITS +: CH_BITS];
        end
    end

    // Stage 2: black for blanking or expiry, shaped color otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                       rgb_o <= '0;
        else if (!s1_active || s1_expired) rgb_o <= '0;
        else                              rgb_o <= shaped;
    end

    assert_expired_black_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s1_expired |=> (rgb_o == '0));

    assert_never_tag_black_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (&tag) |=> ##1 (rgb_o == '0));

    assert_dim_not_brighter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rgb_o[CH_BITS-1:0] <= $past(s1_rgb[CH_BITS-1:0])));

endmodule

// File: rtl/phosphor_readout.sv
// Module: phosphor_readout (top)
// Filters framebuffer read data by frame age to imitate phosphor decay. It
// delays sync and active-video by RD_LAT+2 so that they stay aligned with color.
// Assumes: pix_data returns exactly RD_LAT cycles after the control signals of
// its address; RD_LAT >= 1.
module phosphor_readout
    import phr_pkg::*;
#(
    parameter int CH_BITS  = 4,
    parameter int TAG_BITS = 3,
    parameter int RD_LAT   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          hsync_n_in,
    input  logic                          vsync_n_in,
    input  logic                          active_in,
    input  logic [TAG_BITS+3*CH_BITS-1:0] pix_data,
    input  logic [TAG_BITS-1:0]           age_limit,
    input  logic                          fade_dim,
    output logic [CH_BITS-1:0]            red,
    output logic [CH_BITS-1:0]            green,
    output logic [CH_BITS-1:0]            blue,
    output logic                          hsync_n,
    output logic                          vsync_n,
    output logic                          active
);
    localparam int FILT_STAGES = 2;
    localparam int CTL_DEPTH   = RD_LAT + FILT_STAGES;

    raster_ctl_t         ctl_in;
    raster_ctl_t         ctl_out;
    logic                act_at_data;
    logic [TAG_BITS-1:0] frame_now;
    logic [3*CH_BITS-1:0] rgb;

    assign ctl_in = '{hsync_n: hsync_n_in, vsync_n: vsync_n_in, active: active_in};

    phr_frame_counter #(.TAG_BITS(TAG_BITS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .vsync_n_in (vsync_n_in),
        .frame_o    (frame_now)
    );

    phr_ctl_delay #(.DEPTH(CTL_DEPTH), .TAP(RD_LAT)) u_delay (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_i        (ctl_in),
        .tap_active_o (act_at_data),
        .ctl_o        (ctl_out)
    );

    phr_age_filter #(.CH_BITS(CH_BITS), .TAG_BITS(TAG_BITS)) u_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .pix_i       (pix_data),
        .active_i    (act_at_data),
        .frame_i     (frame_now),
        .age_limit_i (age_limit),
        .dim_i       (fade_dim),
        .rgb_o       (rgb)
    );

    assign red     = rgb[2*CH_BITS +: CH_BITS];
    assign green   = rgb[CH_BITS +: CH_BITS];
    assign blue    = rgb[0 +: CH_BITS];
    assign hsync_n = ctl_out.hsync_n;
    assign vsync_n = ctl_out.vsync_n;
    assign active  = ctl_out.active;

    assert_blank_is_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (rgb == '0));

endmodule

// File: tb/phosphor_readout_test.sv
// Scoreboard bench: the driver computes each expected output from the
// requirements and queues it; the monitor compares it two cycles later.
module phosphor_readout_test;
    localparam int CH  = 4;
    localparam int TG  = 3;
    localparam int RL  = 2;
    localparam int PER = (1 << TG) - 1;

    typedef struct {
        int          due;
        logic [2:0]  ctl;
        logic [11:0] rgb;
        string       lbl;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_in = 1'b1, vs_in = 1'b1, act_in = 1'b0;
    logic [TG+3*CH-1:0] pix = '0;
    logic [TG-1:0] lim = 3'd2;
    logic dim = 1'b0;
    logic [CH-1:0] red, green, blue;
    logic hsync_n, vsync_n, active;

    int checks = 0, fails = 0, cyc = 0;
    int exp_frame = 0, frames_seen = 0;
    logic prev_vs = 1'b1;
    item_t sb[$];
    logic [2:0] hist[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    phosphor_readout #(.CH_BITS(CH), .TAG_BITS(TG), .RD_LAT(RL)) uut (
        .clk(clk), .rst_n(rst_n), .hsync_n_in(hs_in), .vsync_n_in(vs_in),
        .active_in(act_in), .pix_data(pix), .age_limit(lim), .fade_dim(dim),
        .red(red), .green(green), .blue(blue),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .active(active));

    task automatic check(input bit ok, input string req, input logic [15:0] act_v, input logic [15:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act_v, exp_v, cyc);
        end
    endtask

    // Drive one cycle and queue the expected output. R9: word = {tag, red, green, blue}.
    task automatic drive(input logic hs, input logic vs, input logic ac, input logic [2:0] tag, input logic [11:0] col);
        item_t it;
        logic [2:0] old;
        int age;
        @(negedge clk);
        hs_in = hs; vs_in = vs; act_in = ac; pix = {tag, col};
        hist.push_back({hs, vs, ac});
        old = hist.pop_front();
        it.due = cyc + 2;
        it.ctl = old;
        age = (exp_frame - int'(tag) + PER) % PER;
        if (!old[0]) begin
            it.rgb = '0; it.lbl = "R8";
        end else if (tag == 3'd7) begin
            it.rgb = '0; it.lbl = "R7";
        end else begin
            it.lbl = dim ? "R6 R9 R2" : "R5 R9 R2";
            if (int'(tag) > exp_frame) it.lbl = {it.lbl, " R4"};
            if (frames_seen >= PER) it.lbl = {it.lbl, " R10"};
            if (age > int'(lim))  it.rgb = '0;
            else if (dim)        it.rgb = {col[11:8] >> age, col[7:4] >> age, col[3:0] >> age};
            else                 it.rgb = col;
        end
        sb.push_back(it);
        if (prev_vs && !vs) begin
            exp_frame = (exp_frame == PER-1) ? 0 : exp_frame + 1;
            frames_seen++;
        end
        prev_vs = vs;
    endtask

    // One short frame: active run with periodic hblank, then a vsync gap.
    task automatic frame(input int n);
        for (int i = 0; i < n; i++) begin
            logic blank_c;
            blank_c = (i % 5 == 4);
            drive(!blank_c, 1'b1, !blank_c, 3'($urandom % 8), 12'($urandom));
        end
        drive(1'b1, 1'b1, 1'b0, 3'd0, 12'hFFF);
        drive(1'b1, 1'b1, 1'b0, 3'd0, 12'hFFF);
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b0, 3'($urandom % 8), 12'hABC);
        drive(1'b1, 1'b1, 1'b0, 3'd0, 12'h000);
    endtask

    // Monitor: pop due items and compare (R3 for control, listed tags for color).
    always @(negedge clk) begin
        if (rst_n && sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            check({hsync_n, vsync_n, active} == it.ctl, "R3", 16'({hsync_n, vsync_n, active}), 16'(it.ctl));
            check({red, green, blue} == it.rgb, it.lbl, 16'({red, green, blue}), 16'(it.rgb));
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < RL; i++) hist.push_back(3'b110);
        repeat (4) @(negedge clk);
        // R1: idle outputs during reset.
        check({red, green, blue} == 12'h000, "R1", 16'({red, green, blue}), 16'h0);
        check({hsync_n, vsync_n, active} == 3'b110, "R1", 16'({hsync_n, vsync_n, active}), 16'h6);
        rst_n = 1'b1;
        @(negedge clk);
        check({red, green, blue, hsync_n, vsync_n, active} == 15'b110, "R1",
              16'({red, green, blue, hsync_n, vsync_n, active}), 16'h6);
        // Directed R7 and R8 words ahead of random traffic.
        drive(1'b1, 1'b1, 1'b1, 3'd7, 12'hFFF);
        drive(1'b1, 1'b1, 1'b1, 3'd0, 12'hFFF);
        drive(1'b1, 1'b1, 1'b1, 3'd0, 12'hFFF);
        drive(1'b1, 1'b1, 1'b0, 3'd7, 12'hFFF);
        drive(1'b1, 1'b1, 1'b0, 3'd0, 12'h5A5);
        drive(1'b1, 1'b1, 1'b0, 3'd0, 12'h5A5);
        lim = 3'd2; dim = 1'b0;
        for (int f = 0; f < 9; f++) frame(20);
        lim = 3'd6; dim = 1'b1;
        for (int f = 0; f < 9; f++) frame(20);
        lim = 3'd0; dim = 1'b0;
        for (int f = 0; f < 3; f++) frame(20);
        lim = 3'd1; dim = 1'b1;
        for (int f = 0; f < 3; f++) frame(20);
        repeat (6) @(negedge clk);
        check(sb.size() == 0, "R3", 16'(sb.size()), 16'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule